// File: doc/BRIEF.md
# Segmented CAM Host Access Controller

This block sits between a host and a content-addressable memory whose words are 64 bits wide, reached through a 32-bit bidirectional data bus. Three active-low inputs (chip enable, write enable, command enable) are sampled in one clock domain. The first low sample of the chip enable opens a bus cycle and latches the cycle type and the bus data. The next high sample closes it. There are four cycle types: data read, data write, command read and command write.

Data cycles go to a persistent target: the comparand, mask 1, mask 2 or the memory array. A separate selector exists for reads and for writes. Each selector has a segment counter that walks the two 32-bit halves of a word and steps when the cycle closes. Command writes carry a 16-bit instruction on the upper bus half and an operand on the lower half. Instructions set the selectors, write or read back configuration registers through a one-shot override, switch between a foreground and a background register bank, and issue memory commands. Command reads return a status word supplied by the match logic.

Top module: `cam_hif`

## Requirements
- R1: After reset the foreground bank (bank_o=0) is active, both selectors point to the comparand (target code 0), both segment counters are 0, the control and address registers are 0, and no strobe or output enable is active.
- R2: A data write (cmd_ni=1, we_ni=0) pulses exactly one bit of tgt_wr_o for one cycle, at the index of the active write selector (0 comparand, 1 mask 1, 2 mask 2, 3 memory), with wdata_o equal to the bus value latched when the cycle opened.
- R3: A data read (cmd_ni=1, we_ni=1) pulses one bit of tgt_rd_o at the index of the active read selector, and dq_o carries tgt_rdata_i with dq_oe_o high only while the chip enable is held low. It never coincides with a write strobe.
- R4: seg_o reports the half being accessed (0 = bits 31..0, 1 = bits 63..32). The write counter steps after a data write closes and the read counter steps after a data read closes. Each wraps from 1 to 0, and command cycles leave both unchanged.
- R5: Opcode 1 (instruction bits 15..12) sets the read selector and opcode 2 sets the write selector, each from instruction bits 1..0. Each leaves the other selector unchanged and clears its own segment counter.
- R6: With no override armed, a command read (cmd_ni=0, we_ni=1) returns the full 32-bit status_i.
- R7: Opcode 3 with the field flag (instruction bit 11) set writes operand bits 15..0 into the register named by instruction bits 1..0: 0 control, 1 segment control, 2 address, 3 selectors (read at bits 5..4, write at bits 1..0, both counters cleared). Instructions whose bits 10..2 are not zero have no effect.
- R8: Opcode 3 with the flag clear arms a one-shot override. The next command read returns status_i bits 31..16 above the named register, with the selectors reading back as R7 lays them out. Closing that read, or any other command write, disarms it.
- R9: Opcode 5 selects the background bank and opcode 4 the foreground bank. Control, segment control, address and both selectors are kept per bank. Each bank starts in the R1 state, and a bank switch clears both segment counters.
- R10: Opcode 6 pulses mem_cmd_o for one cycle. With the flag set the address register is loaded from the operand and addr_o shows the new address during the pulse. With the flag clear the stored address is used and the operand is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low; frames each bus cycle |
| we_ni | input | 1 | Write enable, active low |
| cmd_ni | input | 1 | Command enable, active low |
| dq_i | input | 32 | Bus data from host |
| dq_o | output | 32 | Bus data to host |
| dq_oe_o | output | 1 | Bus output enable |
| status_i | input | 32 | Status word from the match logic |
| tgt_rdata_i | input | 32 | Read data from the selected target half |
| tgt_wr_o | output | 4 | One-hot write strobe per target |
| tgt_rd_o | output | 4 | One-hot read strobe per target |
| seg_o | output | 1 | Word half of the current strobe |
| wdata_o | output | 32 | Write data for the target half |
| addr_o | output | 16 | Active memory address |
| mem_cmd_o | output | 1 | Memory command pulse |
| ctrl_o | output | 16 | Active control register |
| bank_o | output | 1 | Active bank, 1 = background |

## Verification
Target strobes, mem_cmd_o and the read output enable appear in the first cycle after the clock edge that samples the chip enable low. Register and bank changes from a command write are in place one cycle later, and segment counters step one cycle after the edge that sees the enable high again. The bench drives inputs and samples outputs on the falling clock edge. It releases the enable after one sampled cycle and waits one more cycle before the next access or register check, so every result is read after its due edge and before the next cycle can change it. A monitor matches each strobe, in order, against a queue of expected target, half and data values that the driver pushes before each access.

// File: rtl/cam_hif_pkg.sv
`timescale 1ns/1ps
package cam_hif_pkg;
  localparam int BUS_W    = 32;
  localparam int WORD_W   = 64;
  localparam int REG_W    = 16;
  localparam int NUM_TGT  = 4;
  localparam int NUM_BANK = 2;
  localparam int FLAG_BIT = 11;

  typedef enum logic [1:0] {TGT_CMP = 2'd0, TGT_MSK1 = 2'd1, TGT_MSK2 = 2'd2, TGT_MEM = 2'd3} tgt_e;
  typedef enum logic [1:0] {CYC_DRD, CYC_DWR, CYC_CRD, CYC_CWR} cyc_e;
  typedef enum logic [1:0] {REG_CTRL = 2'd0, REG_SEGC = 2'd1, REG_ADDR = 2'd2, REG_SEL = 2'd3} reg_e;

  localparam logic [3:0] OP_NOP = 4'h0;
  localparam logic [3:0] OP_SPS = 4'h1;
  localparam logic [3:0] OP_SPD = 4'h2;
  localparam logic [3:0] OP_TCO = 4'h3;
  localparam logic [3:0] OP_SFG = 4'h4;
  localparam logic [3:0] OP_SBG = 4'h5;
  localparam logic [3:0] OP_MEM = 4'h6;

  typedef struct packed {
    logic [REG_W-1:0] ctrl;
    logic [REG_W-1:0] segc;
    logic [REG_W-1:0] addr;
    tgt_e             ps;
    tgt_e             pd;
  } bank_t;
endpackage

// File: rtl/cam_hif_edge.sv
`timescale 1ns/1ps
module cam_hif_edge
  import cam_hif_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          cmd_ni,
  input  logic [DW-1:0] dq_i,
  output logic          start_o,
  output logic          end_o,
  output logic          active_o,
  output cyc_e          cyc_o,
  output logic [DW-1:0] data_o
);
  logic ce_q;
  logic fall, rise;
  cyc_e cyc_d;

  assign fall = ce_q & ~ce_ni;
  assign rise = ~ce_q & ce_ni;

  always_comb begin
    if (cmd_ni) cyc_d = we_ni ? CYC_DRD : CYC_DWR;
    else        cyc_d = we_ni ? CYC_CRD : CYC_CWR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q     <= 1'b1;
      start_o  <= 1'b0;
      end_o    <= 1'b0;
      active_o <= 1'b0;
      cyc_o    <= CYC_DRD;
      data_o   <= '0;
    end else begin
      ce_q    <= ce_ni;
      start_o <= fall;
      end_o   <= rise;
      if (fall) begin
        cyc_o    <= cyc_d;
        data_o   <= dq_i;
        active_o <= 1'b1;
      end else if (rise) begin
        active_o <= 1'b0;
      end
    end
  end

  AST_START_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> active_o); // R3
  AST_START_END_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && end_o)); // R4
endmodule

// File: rtl/cam_hif_seg.sv
`timescale 1ns/1ps
module cam_hif_seg #(
  parameter  int SEGS = 2,
  localparam int SW   = (SEGS > 1) ? $clog2(SEGS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [SW-1:0] seg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    seg_o <= '0;
    else if (clr_i) seg_o <= '0;
    else if (adv_i) seg_o <= (seg_o == SW'(SEGS - 1)) ? '0 : seg_o + 1'b1;
  end

  AST_SEG_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> seg_o == '0); // R5
  AST_SEG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !adv_i) |=> $stable(seg_o)); // R4
endmodule

// File: rtl/cam_hif_bank.sv
`timescale 1ns/1ps
module cam_hif_bank
  import cam_hif_pkg::*;
#(
  parameter  int NB = 2,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_we_i,
  input  logic [BW-1:0] sel_i,
  input  logic          upd_we_i,
  input  bank_t         upd_i,
  output bank_t         act_o,
  output logic [BW-1:0] bank_o
);
  bank_t banks [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    bank_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           q <= '0;
      else if (upd_we_i && bank_o == BW'(b)) q <= upd_i;
    end
    assign banks[b] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bank_o <= '0;
    else if (sel_we_i) bank_o <= sel_i;
  end

  assign act_o = banks[bank_o];

  AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_we_i && !sel_we_i) |=> $stable(act_o)); // R9
endmodule

// File: rtl/cam_hif.sv
`timescale 1ns/1ps
module cam_hif
  import cam_hif_pkg::*;
#(
  parameter  int DW     = BUS_W,
  parameter  int WW     = WORD_W,
  localparam int RW     = REG_W,
  localparam int NT     = NUM_TGT,
  localparam int SEGS   = WW / DW,
  localparam int SW     = (SEGS > 1) ? $clog2(SEGS) : 1,
  localparam int BW     = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          cmd_ni,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] tgt_rdata_i,
  output logic [NT-1:0] tgt_wr_o,
  output logic [NT-1:0] tgt_rd_o,
  output logic [SW-1:0] seg_o,
  output logic [DW-1:0] wdata_o,
  output logic [RW-1:0] addr_o,
  output logic          mem_cmd_o,
  output logic [RW-1:0] ctrl_o,
  output logic [BW-1:0] bank_o
);
  logic          start_q, end_q, active_q;
  cyc_e          cyc_q;
  logic [DW-1:0] data_q;

  cam_hif_edge #(.DW(DW)) u_edge (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .cmd_ni, .dq_i,
    .start_o(start_q), .end_o(end_q), .active_o(active_q),
    .cyc_o(cyc_q), .data_o(data_q)
  );

  logic [RW-1:0] instr, oper;
  logic [3:0]    op;
  logic          flag, rsv_ok;
  logic [1:0]    fld;
  assign instr  = data_q[DW-1 -: RW];
  assign oper   = data_q[RW-1:0];
  assign op     = instr[RW-1 -: 4];
  assign flag   = instr[FLAG_BIT];
  assign fld    = instr[1:0];
  assign rsv_ok = (instr[FLAG_BIT-1:2] == '0);

  bank_t         act, nxt;
  logic          upd_we, sel_we, src_clr, dst_clr;
  logic          tco_set, tco_clr, mem_hit;
  logic [BW-1:0] sel_v;
  logic          cwr;

  assign cwr = start_q && (cyc_q == CYC_CWR);

  always_comb begin
    nxt     = act;
    upd_we  = 1'b0;
    sel_we  = 1'b0;
    sel_v   = bank_o;
    src_clr = 1'b0;
    dst_clr = 1'b0;
    tco_set = 1'b0;
    tco_clr = cwr;
    mem_hit = 1'b0;
    if (cwr && rsv_ok) begin
      unique case (op)
        OP_SPS: begin nxt.ps = tgt_e'(fld); upd_we = 1'b1; src_clr = 1'b1; end
        OP_SPD: begin nxt.pd = tgt_e'(fld); upd_we = 1'b1; dst_clr = 1'b1; end
        OP_TCO: begin
          if (flag) begin
            upd_we = 1'b1;
            unique case (reg_e'(fld))
              REG_CTRL: nxt.ctrl = oper;
              REG_SEGC: nxt.segc = oper;
              REG_ADDR: nxt.addr = oper;
              REG_SEL: begin
                nxt.ps  = tgt_e'(oper[5:4]);
                nxt.pd  = tgt_e'(oper[1:0]);
                src_clr = 1'b1;
                dst_clr = 1'b1;
              end
            endcase
          end else begin
            tco_set = 1'b1;
            tco_clr = 1'b0;
          end
        end
        OP_SFG: begin sel_we = 1'b1; sel_v = BW'(0); end
        OP_SBG: begin sel_we = 1'b1; sel_v = BW'(1); end
        OP_MEM: begin
          mem_hit = 1'b1;
          if (flag) begin nxt.addr = oper; upd_we = 1'b1; end
        end
        default: ;
      endcase
    end
  end

  cam_hif_bank #(.NB(NUM_BANK)) u_bank (
    .clk_i, .rst_ni,
    .sel_we_i(sel_we), .sel_i(sel_v),
    .upd_we_i(upd_we), .upd_i(nxt),
    .act_o(act), .bank_o(bank_o)
  );

  // one-shot override state
  logic tco_arm;
  reg_e tco_id;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tco_arm <= 1'b0;
      tco_id  <= REG_CTRL;
    end else if (tco_set) begin
      tco_arm <= 1'b1;
      tco_id  <= reg_e'(fld);
    end else if (tco_clr || (end_q && cyc_q == CYC_CRD)) begin
      tco_arm <= 1'b0;
    end
  end

  logic [SW-1:0] sseg, dseg;
  cam_hif_seg #(.SEGS(SEGS)) u_src_seg (
    .clk_i, .rst_ni, .clr_i(src_clr | sel_we),
    .adv_i(end_q && cyc_q == CYC_DRD), .seg_o(sseg)
  );
  cam_hif_seg #(.SEGS(SEGS)) u_dst_seg (
    .clk_i, .rst_ni, .clr_i(dst_clr | sel_we),
    .adv_i(end_q && cyc_q == CYC_DWR), .seg_o(dseg)
  );

  logic [RW-1:0] rb;
  always_comb begin
    unique case (tco_id)
      REG_CTRL: rb = act.ctrl;
      REG_SEGC: rb = act.segc;
      REG_ADDR: rb = act.addr;
      REG_SEL:  rb = {{(RW-6){1'b0}}, act.ps, 2'b00, act.pd};
    endcase
  end

  assign tgt_wr_o  = (start_q && cyc_q == CYC_DWR) ? (NT'(1) << act.pd) : '0;
  assign tgt_rd_o  = (start_q && cyc_q == CYC_DRD) ? (NT'(1) << act.ps) : '0;
  assign seg_o     = (cyc_q == CYC_DWR) ? dseg : sseg;
  assign wdata_o   = data_q;
  assign mem_cmd_o = mem_hit;
  assign addr_o    = (mem_hit && flag) ? oper : act.addr;
  assign ctrl_o    = act.ctrl;
  assign dq_oe_o   = active_q && (cyc_q == CYC_DRD || cyc_q == CYC_CRD);

  always_comb begin
    dq_o = '0;
    if (dq_oe_o) begin
      if (cyc_q == CYC_DRD) dq_o = tgt_rdata_i;
      else if (tco_arm)     dq_o = {status_i[DW-1:RW], rb};
      else                  dq_o = status_i;
    end
  end

  AST_WR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tgt_wr_o)); // R2
  AST_WR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_wr_o != '0) |=> (tgt_wr_o == '0)); // R2
  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((tgt_wr_o != '0) && (tgt_rd_o != '0))); // R3
  AST_OE_NEEDS_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> !$past(ce_ni)); // R3
  AST_MEM_ADDR_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_cmd_o |=> (addr_o == $past(addr_o))); // R10
endmodule

// File: tb/cam_hif_tb_top.sv
`timescale 1ns/1ps
module cam_hif_tb_top;
  localparam logic [31:0] STAT = 32'hA5C3_0F1E;
  localparam int WD_CYCLES = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_ni = 1'b1, we_ni = 1'b1, cmd_ni = 1'b1;
  logic [31:0] dq_i = '0, tgt_rdata_i = '0;
  logic [31:0] status_i = STAT;
  logic [31:0] dq_o, wdata_o;
  logic        dq_oe_o, mem_cmd_o;
  logic [3:0]  tgt_wr_o, tgt_rd_o;
  logic        seg_o, bank_o;
  logic [15:0] addr_o, ctrl_o;

  always #2.5 clk_i = ~clk_i;

  cam_hif dut_i (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .cmd_ni, .dq_i, .dq_o, .dq_oe_o,
    .status_i, .tgt_rdata_i, .tgt_wr_o, .tgt_rd_o, .seg_o, .wdata_o,
    .addr_o, .mem_cmd_o, .ctrl_o, .bank_o
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard: kind 0 write, 1 read, 2 memory command
  typedef struct {
    int          kind;
    logic [3:0]  strb;
    logic        seg;
    logic [31:0] val;
    string       req;
  } exp_t;
  exp_t sb[$];

  always @(negedge clk_i) begin
    if (rst_ni && ((tgt_wr_o != 0) || (tgt_rd_o != 0) || mem_cmd_o)) begin
      if (sb.size() == 0) begin
        chk("unexpected strobe", {tgt_wr_o, tgt_rd_o, 24'h0}, 32'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (e.kind == 0) begin
          chk({e.req, " wr strobe"}, {28'h0, tgt_wr_o}, {28'h0, e.strb});
          chk({e.req, " wr seg"},    {31'h0, seg_o}, {31'h0, e.seg});
          chk({e.req, " wr data"},   wdata_o, e.val);
        end else if (e.kind == 1) begin
          chk({e.req, " rd strobe"}, {28'h0, tgt_rd_o}, {28'h0, e.strb});
          chk({e.req, " rd seg"},    {31'h0, seg_o}, {31'h0, e.seg});
        end else begin
          chk({e.req, " mem cmd"},   {31'h0, mem_cmd_o}, 32'h1);
          chk({e.req, " mem addr"},  {16'h0, addr_o}, e.val);
        end
      end
    end
  end

  task automatic bus(input logic we, input logic cm, input logic [31:0] d,
                     input logic [31:0] rdat, output logic [31:0] q, output logic oe);
    @(negedge clk_i);
    ce_ni = 1'b0; we_ni = we; cmd_ni = cm; dq_i = d; tgt_rdata_i = rdat;
    @(negedge clk_i);
    q = dq_o; oe = dq_oe_o;
    ce_ni = 1'b1; we_ni = 1'b1; cmd_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic dwrite(input logic [31:0] d, input int tgt, input logic seg, input string req);
    logic [31:0] q; logic oe;
    exp_t e;
    e.kind = 0; e.strb = 4'(1 << tgt); e.seg = seg; e.val = d; e.req = req;
    sb.push_back(e);
    bus(1'b0, 1'b1, d, '0, q, oe);
  endtask

  task automatic dread(input logic [31:0] rdat, input int tgt, input logic seg, input string req);
    logic [31:0] q; logic oe;
    exp_t e;
    e.kind = 1; e.strb = 4'(1 << tgt); e.seg = seg; e.val = '0; e.req = req;
    sb.push_back(e);
    bus(1'b1, 1'b1, 32'h0, rdat, q, oe);
    chk({req, " read data"}, q, rdat);
    chk({req, " read oe"}, {31'h0, oe}, 32'h1);
  endtask

  task automatic cwrite(input logic [15:0] ins, input logic [15:0] opnd);
    logic [31:0] q; logic oe;
    bus(1'b0, 1'b0, {ins, opnd}, '0, q, oe);
  endtask

  task automatic cread(input logic [31:0] exp, input string req);
    logic [31:0] q; logic oe;
    bus(1'b1, 1'b0, 32'h0, '0, q, oe);
    chk({req, " cmd read"}, q, exp);
  endtask

  task automatic memcmd(input logic [15:0] ins, input logic [15:0] opnd, input logic [15:0] exp_addr);
    exp_t e;
    e.kind = 2; e.strb = '0; e.seg = 1'b0; e.val = {16'h0, exp_addr}; e.req = "R10";
    sb.push_back(e);
    cwrite(ins, opnd);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 oe", {31'h0, dq_oe_o}, 32'h0);
    chk("R1 bank", {31'h0, bank_o}, 32'h0);
    chk("R1 strobes", {24'h0, tgt_wr_o, tgt_rd_o}, 32'h0);
    chk("R1 ctrl/addr", {ctrl_o, addr_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    cread(STAT, "R6 default status");

    // R2/R4: default comparand destination, half order and wrap
    dwrite(32'h1111_1111, 0, 1'b0, "R2 R4 first");
    dwrite(32'h2222_2222, 0, 1'b1, "R4 second half");
    dwrite(32'h3333_3333, 0, 1'b0, "R4 wrap");
    // R1/R3 default comparand source
    dread(32'hDEAD_0001, 0, 1'b0, "R3 R1 source");
    dread(32'hDEAD_0002, 0, 1'b1, "R3 R4 source half");

    // R5 independent selectors, counter clear
    cwrite(16'h2002, 16'h0);
    dwrite(32'h4444_4444, 2, 1'b0, "R5 dest mask2");
    dread(32'hBEEF_0003, 0, 1'b0, "R5 source untouched");
    cwrite(16'h2003, 16'h0);
    dwrite(32'h5555_5555, 3, 1'b0, "R5 dest memory cleared");
    cwrite(16'h1001, 16'h0);
    dread(32'hBEEF_0004, 1, 1'b0, "R5 source mask1");
    cwrite(16'h1000, 16'h0);

    // R7 flagged override writes, reserved bits
    cwrite(16'h3800, 16'h1234);
    chk("R7 ctrl", {16'h0, ctrl_o}, 32'h1234);
    cwrite(16'h3802, 16'h0042);
    chk("R7 addr", {16'h0, addr_o}, 32'h0042);
    cwrite(16'h3810, 16'h9999);
    chk("R7 reserved ignored", {16'h0, ctrl_o}, 32'h1234);

    // R8 one-shot readback
    cwrite(16'h3000, 16'h0);
    cread({STAT[31:16], 16'h1234}, "R8 ctrl readback");
    cread(STAT, "R8 one-shot expired");
    cwrite(16'h3002, 16'h0);
    cwrite(16'h0000, 16'h0);
    cread(STAT, "R8 cancelled by command");
    cwrite(16'h3003, 16'h0);
    cread({STAT[31:16], 16'h0003}, "R8 selectors readback");

    // R9 banks
    cwrite(16'h5000, 16'h0);
    chk("R9 bank bg", {31'h0, bank_o}, 32'h1);
    chk("R9 bg reset regs", {ctrl_o, addr_o}, 32'h0);
    dwrite(32'h6666_6666, 0, 1'b0, "R9 bg dest comparand");
    cwrite(16'h3800, 16'hBEEF);
    chk("R9 bg ctrl", {16'h0, ctrl_o}, 32'hBEEF);
    cwrite(16'h4000, 16'h0);
    chk("R9 fg ctrl kept", {16'h0, ctrl_o}, 32'h1234);
    chk("R9 bank fg", {31'h0, bank_o}, 32'h0);
    dwrite(32'h7777_7777, 3, 1'b0, "R9 fg dest memory, counter cleared");

    // R10 memory command
    memcmd(16'h6800, 16'h0777, 16'h0777);
    chk("R10 addr loaded", {16'h0, addr_o}, 32'h0777);
    memcmd(16'h6000, 16'h0999, 16'h0777);
    chk("R10 operand ignored", {16'h0, addr_o}, 32'h0777);

    repeat (2) @(negedge clk_i);
    chk("scoreboard drained", sb.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule